// File: doc/BRIEF.md
# Keyed Watchdog with Two-Stage Expiry

This block is a watchdog timer. It is guarded by one 16-bit control word. Software restarts the countdown by writing the control word. Once the watchdog is enabled, each write must carry a 7-bit key that is the bitwise inverse of the key stored by the previous accepted write. A runaway program that repeats the same write therefore cannot keep the watchdog alive.

The countdown advances only on cycles where the external low-rate tick strobe is high. When the count runs out for the first time, the block raises a non-maskable interrupt as a warning and starts a grace countdown of 10 ticks. If the grace countdown also runs out before software makes an accepted write, the block emits a one-cycle system reset request. The stored control word and the remaining tick count are brought out as outputs so that the host can read them.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset, `ctrl_word` is 0, `ticks_left` is 0, `nmi` and `reset_req` are low, and the countdown is stopped.
- R2: While bit 8 of the stored `ctrl_word` is 0, every write is accepted, whatever key it carries.
- R3: While bit 8 of the stored `ctrl_word` is 1, a write is accepted only when its bits [15:9] equal the 7-bit inverse of the stored bits [15:9]. A rejected write leaves `ctrl_word`, `ticks_left` and `nmi` unchanged.
- R4: An accepted write stores the written word in `ctrl_word` in the next cycle. It also loads `ticks_left` from bits [8:0] of the word, and a value of 0 in that field loads 256.
- R5: Bit 8 of an accepted write selects the mode: 1 runs the countdown and 0 stops it. While the countdown is stopped, ticks leave `ticks_left` unchanged.
- R6: While the countdown runs, each cycle with `tick` high lowers `ticks_left` by one. The first expiry happens on the tick that would take `ticks_left` from 1 to 0. After that tick, `nmi` is high and `ticks_left` is 10, and the countdown keeps running.
- R7: A second expiry with no accepted write since the first one drives `reset_req` high for exactly one cycle. After it, `ticks_left` is 0, the countdown is stopped, and `nmi` stays high.
- R8: An accepted write drops `nmi` in the next cycle and clears the expiry history, so the next expiry again counts as a first expiry.
- R9: Cycles with `tick` low do not change `ticks_left`. When an accepted write and a tick fall in the same cycle, the write takes effect and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle countdown strobe from an external prescaler |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Written word: [15:9] key, [8] run/enable, [8:0] count |
| ctrl_word | output | 16 | Currently stored control word |
| ticks_left | output | 9 | Remaining ticks of the active countdown |
| nmi | output | 1 | Warning interrupt level, set at the first expiry |
| reset_req | output | 1 | One-cycle system reset request at the second expiry |

## Verification
The assertions check four things on every cycle:
- `reset_req` never lasts longer than one cycle and never rises without `nmi`.
- `nmi` holds until an accepted write, and falls right after one.
- A rejected write leaves the stored word alone.
- A stopped counter holds its value.

Only the bench's scenarios can show the following:
- the exact tick on which each expiry lands
- the 256 load for a zero count field
- the 10-tick grace length
- the accept/reject decision across a chain of inverted keys
- a write winning over a tick in the same cycle

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CNT_W     = 9;
    localparam int KEY_W     = 7;
    localparam int WORD_W    = CNT_W + KEY_W;
    localparam int RUN_BIT   = CNT_W - 1;
    localparam int ZERO_LOAD = 256;
    localparam int GRACE     = 10;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [CNT_W-1:0] count;
    } wd_word_t;

    typedef enum logic [1:0] {
        STG_ARMED  = 2'd0,
        STG_WARNED = 2'd1,
        STG_FIRED  = 2'd2
    } wd_stage_t;

    function automatic logic key_pass(input wd_word_t held, input wd_word_t fresh);
        return (!held.count[RUN_BIT]) || (fresh.key == ~held.key);
    endfunction

    function automatic logic [CNT_W-1:0] start_count(input wd_word_t fresh);
        return (fresh.count == '0) ? CNT_W'(ZERO_LOAD) : fresh.count;
    endfunction

endpackage

// File: rtl/wdog_keygate.sv
module wdog_keygate
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  wd_word_t         wr_word,
    output wd_word_t         held_word,
    output logic             accept,
    output logic [CNT_W-1:0] load_val,
    output logic             load_run
);
    wd_word_t held_q;

    always_comb begin
        accept   = wr_en && key_pass(held_q, wr_word);
        load_val = start_count(wr_word);
        load_run = wr_word.count[RUN_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst)         held_q <= '0;
        else if (accept) held_q <= wr_word;
    end

    assign held_word = held_q;

    assert_reject_keeps_word_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !accept) |=> $stable(held_q));

    assert_accept_stores_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (held_q == $past(wr_word)));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int GRACE_TICKS = GRACE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_run,
    input  logic             grace_en,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign expire = !load && run_q && tick && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= load_val;
            run_q <= load_run;
        end else if (expire) begin
            if (grace_en) begin
                cnt_q <= CNT_W'(GRACE_TICKS);
            end else begin
                cnt_q <= '0;
                run_q <= 1'b0;
            end
        end else if (run_q && tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign count = cnt_q;

    assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !load) |=> $stable(cnt_q));

    assert_idle_tick_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic expire,
    output logic grace_en,
    output logic nmi,
    output logic reset_req
);
    wd_stage_t stg_q;
    logic      req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= STG_ARMED;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (clear) begin
                stg_q <= STG_ARMED;
            end else if (expire) begin
                case (stg_q)
                    STG_ARMED:  stg_q <= STG_WARNED;
                    STG_WARNED: begin
                        stg_q <= STG_FIRED;
                        req_q <= 1'b1;
                    end
                    default:    stg_q <= STG_FIRED;
                endcase
            end
        end
    end

    assign grace_en  = (stg_q == STG_ARMED);
    assign nmi       = (stg_q != STG_ARMED);
    assign reset_req = req_q;

    assert_req_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    assert_req_needs_nmi_R7: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> nmi);

    assert_nmi_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (nmi && !clear) |=> nmi);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdog_pkg::*;
#(
    parameter int GRACE_TICKS = GRACE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [CNT_W-1:0]  ticks_left,
    output logic              nmi,
    output logic              reset_req
);
    wd_word_t         held_word;
    logic             accept;
    logic [CNT_W-1:0] load_val;
    logic             load_run;
    logic             grace_en;
    logic             expire;

    wdog_keygate u_gate (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_word   (wd_word_t'(wr_data)),
        .held_word (held_word),
        .accept    (accept),
        .load_val  (load_val),
        .load_run  (load_run)
    );

    wdog_counter #(.GRACE_TICKS(GRACE_TICKS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (accept),
        .load_val (load_val),
        .load_run (load_run),
        .grace_en (grace_en),
        .expire   (expire),
        .count    (ticks_left)
    );

    wdog_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .expire    (expire),
        .grace_en  (grace_en),
        .nmi       (nmi),
        .reset_req (reset_req)
    );

    assign ctrl_word = held_word;

    assert_accept_drops_nmi_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> !nmi);
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ctrl_word;
    logic [8:0]  ticks_left;
    logic        nmi;
    logic        reset_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        logic        nmi;
        logic        req;
        logic [15:0] word;
        logic [8:0]  left;
    } exp_t;

    exp_t sb_q[$];
    event chk_ev;

    always #4 clk = ~clk;

    keyed_watchdog dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_word(ctrl_word), .ticks_left(ticks_left), .nmi(nmi), .reset_req(reset_req)
    );

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (nmi !== e.nmi) begin
                    fails++;
                    $display("FAIL %s nmi actual=%b expected=%b", e.tag, nmi, e.nmi);
                end
                checks++;
                if (reset_req !== e.req) begin
                    fails++;
                    $display("FAIL %s reset_req actual=%b expected=%b", e.tag, reset_req, e.req);
                end
                checks++;
                if (ctrl_word !== e.word) begin
                    fails++;
                    $display("FAIL %s ctrl_word actual=%h expected=%h", e.tag, ctrl_word, e.word);
                end
                checks++;
                if (ticks_left !== e.left) begin
                    fails++;
                    $display("FAIL %s ticks_left actual=%0d expected=%0d", e.tag, ticks_left, e.left);
                end
            end
        end
    end

    task automatic expect_now(input string tag, input logic n, input logic r,
                              input logic [15:0] w, input logic [8:0] l);
        exp_t e;
        e.tag = tag; e.nmi = n; e.req = r; e.word = w; e.left = l;
        sb_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic step(input logic w, input logic [15:0] d, input logic t);
        wr_en = w; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_now("R1 reset state", 0, 0, 16'h0000, 9'd0);

        // R4: zero count field loads 256; R5: stopped countdown ignores ticks
        step(1'b1, 16'h0000, 1'b0);
        expect_now("R4 zero count loads 256", 0, 0, 16'h0000, 9'd256);
        ticks(5);
        expect_now("R5 stopped holds", 0, 0, 16'h0000, 9'd256);

        // R2: disabled, any key accepted; run with count 0x103 = 259
        step(1'b1, 16'h2B03, 1'b0);
        expect_now("R2 R4 load 259", 0, 0, 16'h2B03, 9'd259);
        ticks(258);
        expect_now("R6 one tick left", 0, 0, 16'h2B03, 9'd1);
        ticks(1);
        expect_now("R6 first expiry nmi and grace", 1, 0, 16'h2B03, 9'd10);

        // R3: same key again (not inverted) is rejected
        step(1'b1, 16'h2B03, 1'b0);
        expect_now("R3 wrong key ignored", 1, 0, 16'h2B03, 9'd10);
        ticks(9);
        expect_now("R6 grace nearly done", 1, 0, 16'h2B03, 9'd1);
        ticks(1);
        expect_now("R7 reset request pulse", 1, 1, 16'h2B03, 9'd0);
        step(1'b0, 16'h0, 1'b0);
        expect_now("R7 pulse ends, nmi holds", 1, 0, 16'h2B03, 9'd0);
        ticks(3);
        expect_now("R7 stopped after request", 1, 0, 16'h2B03, 9'd0);

        // R8: inverted key 0x6A accepted, clears nmi and restarts
        step(1'b1, 16'hD503, 1'b0);
        expect_now("R8 accepted write clears nmi", 0, 0, 16'hD503, 9'd259);
        ticks(259);
        expect_now("R8 history cleared, first expiry again", 1, 0, 16'hD503, 9'd10);

        // R9: write together with tick, key 0x15 = inverse of 0x6A, count 272
        step(1'b1, 16'h2B10, 1'b1);
        expect_now("R9 write beats tick", 0, 0, 16'h2B10, 9'd272);
        step(1'b0, 16'h0, 1'b0);
        expect_now("R9 no tick no change", 0, 0, 16'h2B10, 9'd272);
        ticks(1);
        expect_now("R6 tick decrements", 0, 0, 16'h2B10, 9'd271);

        // R3: rejected write while running keeps countdown
        step(1'b1, 16'h2B05, 1'b0);
        expect_now("R3 reject keeps count", 0, 0, 16'h2B10, 9'd271);

        // R5: accepted stop write (key 0x6A, run bit 0, count 5)
        step(1'b1, 16'hD405, 1'b0);
        expect_now("R5 stop write", 0, 0, 16'hD405, 9'd5);
        ticks(10);
        expect_now("R5 stopped no expiry", 0, 0, 16'hD405, 9'd5);

        // R2: disabled again, arbitrary key accepted
        step(1'b1, 16'h0007, 1'b0);
        expect_now("R2 any key when disabled", 0, 0, 16'h0007, 9'd7);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule